// File: doc/BRIEF.md
# Gated-Clock Parallel-In Serial-Out Shift Register

An eight-stage shift register that converts a parallel byte into a serial bit stream inside one system-clock domain. A low level on the active-low load control makes the stages track the eight parallel inputs on every system clock. This load overrides everything else. While the load control is high, the stages can only shift: each shift moves the contents one place toward the last stage, and the serial input fills the first stage. The last stage is driven out as a true/complement pair.

Shifting is paced by two slow control inputs, a shift clock and a clock inhibit. Each goes through a two-flop synchronizer, and the synchronized levels are ORed into one combined clock. A rising edge of the combined clock causes a shift. Either input can serve as the clock while the other, held low, enables it, or held high, blocks it. The inhibit may only be raised while the shift clock is high. If it rises while the shift clock is low, the combined clock rises, so one shift still happens. A sticky flag records the event.

Top module: `gated_piso_shreg`

## Requirements
- R1: A shift moves stage i into stage i+1 and the serial input into stage 0. Stage 7 is the last stage and drives `q_out`. `par_in[i]` belongs to stage i.
- R2: When `load_n` is low at a system-clock edge, all stages take `par_in` at that edge. This holds whatever the levels of `sclk`, `sinh` and `ser_in`.
- R3: When `load_n` is high, `par_in` has no effect on the stages.
- R4: A shift happens once for each rising edge of the synchronized `sclk | sinh`. The stages change on the third system-clock edge after the raw input change is sampled. While either input is held high, toggling the other produces no shift.
- R5: `q_out_n` is always the complement of `q_out`.
- R6: If `sinh` rises (synchronized) while synchronized `sclk` is low, one shift still happens and `illegal_seen` goes high. The flag stays high until reset.
- R7: A synchronous active-high `rst` clears all stages and `illegal_seen`. Releasing reset while the combined clock is high causes no shift.
- R8: A combined-clock rising edge that is detected in a cycle where `load_n` is low is discarded. It causes no shift after `load_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | 8 | Parallel data, bit i to stage i |
| load_n | input | 1 | Low: stages track par_in |
| sclk | input | 1 | Shift clock input (asynchronous) |
| sinh | input | 1 | Clock inhibit input (asynchronous) |
| q_out | output | 1 | Last stage |
| q_out_n | output | 1 | Complement of last stage |
| illegal_seen | output | 1 | Sticky flag for an inhibit rise while the clock is low |

## Verification
The bench releases reset with the shift clock held high. A design that reset its edge history to zero would make one stray shift there. It raises the shift clock while load is low and then releases load. A design that queued that edge would shift the freshly loaded byte one place. It uses the inhibit both as a blocker and as the clock, including the illegal raise. A design that ignored the inhibit in the OR, or whose flag did not stick, would show a missing shift or a flag that drops back. It also changes the parallel inputs while load is high and toggles serial data during load, which exposes any leakage past the override.

// File: rtl/gated_piso_pkg.sv
package gated_piso_pkg;

    localparam int unsigned STAGES     = 8;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_SHIFT = 2'd2
    } stage_mode_e;

    typedef struct packed {
        logic shift;
        logic illegal;
    } gate_evt_t;

    function automatic stage_mode_e pick_mode(input logic load_n, input logic shift);
        if (!load_n)
            return MODE_LOAD;
        else if (shift)
            return MODE_SHIFT;
        else
            return MODE_HOLD;
    endfunction

endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
    parameter int unsigned WIDTH = 2,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [DEPTH];

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_flop
            if (k == 0) begin : g_first
                always_ff @(posedge clk) chain[k] <= d;
            end else begin : g_next
                always_ff @(posedge clk) chain[k] <= chain[k-1];
            end
        end
    endgenerate

    assign q = chain[DEPTH-1];
endmodule

// File: rtl/psr_gate.sv
module psr_gate
    import gated_piso_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ck_s,
    input  logic      inh_s,
    output gate_evt_t evt,
    output logic      flag
);
    logic comb_now;
    logic comb_prev;
    logic inh_prev;

    assign comb_now    = ck_s | inh_s;
    assign evt.shift   = !rst && comb_now && !comb_prev;
    assign evt.illegal = !rst && inh_s && !inh_prev && !ck_s;

    // History tracks the live level even in reset, so release makes no edge.
    always_ff @(posedge clk) begin
        comb_prev <= comb_now;
        inh_prev  <= inh_s;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (evt.illegal)
            flag <= 1'b1;
    end
endmodule

// File: rtl/psr_stages.sv
module psr_stages
    import gated_piso_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  stage_mode_e  mode,
    input  logic         ser_in,
    input  logic [N-1:0] par_in,
    output logic [N-1:0] stage_q
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_stage
            logic from_prev;
            if (i == 0) begin : g_head
                assign from_prev = ser_in;
            end else begin : g_body
                assign from_prev = stage_q[i-1];
            end

            always_ff @(posedge clk) begin
                if (rst)
                    stage_q[i] <= 1'b0;
                else begin
                    case (mode)
                        MODE_LOAD:  stage_q[i] <= par_in[i];
                        MODE_SHIFT: stage_q[i] <= from_prev;
                        default:    stage_q[i] <= stage_q[i];
                    endcase
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gated_piso_shreg.sv
module gated_piso_shreg
    import gated_piso_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic [STAGES-1:0] par_in,
    input  logic              load_n,
    input  logic              sclk,
    input  logic              sinh,
    output logic              q_out,
    output logic              q_out_n,
    output logic              illegal_seen
);
    logic [1:0]        sync_q;
    gate_evt_t         gate_evt;
    stage_mode_e       mode;
    logic [STAGES-1:0] stage_q;
    logic              shift_evt;

    psr_sync #(.WIDTH(2), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .d   ({sinh, sclk}),
        .q   (sync_q)
    );

    psr_gate u_gate (
        .clk   (clk),
        .rst   (rst),
        .ck_s  (sync_q[0]),
        .inh_s (sync_q[1]),
        .evt   (gate_evt),
        .flag  (illegal_seen)
    );

    assign shift_evt = gate_evt.shift;
    assign mode      = pick_mode(load_n, shift_evt);

    psr_stages #(.N(STAGES)) u_stages (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .ser_in  (ser_in),
        .par_in  (par_in),
        .stage_q (stage_q)
    );

    assign q_out   = stage_q[STAGES-1];
    assign q_out_n = ~stage_q[STAGES-1];
endmodule

// File: rtl/gated_piso_shreg_chk.sv
module gated_piso_shreg_chk #(
    parameter int unsigned N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         ser_in,
    input logic [N-1:0] par_in,
    input logic         load_n,
    input logic         shift_evt,
    input logic [N-1:0] stage_vec,
    input logic         q_out,
    input logic         q_out_n,
    input logic         illegal_seen
);
    // R5
    pair_complement_chk: assert property (@(posedge clk) disable iff (rst)
        q_out_n == ~q_out);

    // R2
    load_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> stage_vec == $past(par_in));

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n && !shift_evt) |=> $stable(stage_vec));

    // R1
    shift_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n && shift_evt) |=> (stage_vec[0] == $past(ser_in)) &&
                                  (stage_vec[N-1:1] == $past(stage_vec[N-2:0])));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_seen |=> illegal_seen);

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (stage_vec == '0) && !illegal_seen);
endmodule

bind gated_piso_shreg gated_piso_shreg_chk #(.N(gated_piso_pkg::STAGES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ser_in       (ser_in),
    .par_in       (par_in),
    .load_n       (load_n),
    .shift_evt    (shift_evt),
    .stage_vec    (stage_q),
    .q_out        (q_out),
    .q_out_n      (q_out_n),
    .illegal_seen (illegal_seen)
);

// File: tb/gated_piso_shreg_tb.sv
module gated_piso_shreg_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_in = 1'b0;
    logic [7:0] par_in = 8'h00;
    logic       load_n = 1'b1;
    logic       sclk = 1'b1;
    logic       sinh = 1'b0;
    logic       q_out, q_out_n, illegal_seen;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string tag = "R7";

    typedef struct { logic q; logic fl; } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    gated_piso_shreg u_dut (
        .clk(clk), .rst(rst), .ser_in(ser_in), .par_in(par_in), .load_n(load_n),
        .sclk(sclk), .sinh(sinh), .q_out(q_out), .q_out_n(q_out_n),
        .illegal_seen(illegal_seen)
    );

    // Reference model: raw inputs pass two sampling flops, then edge logic.
    logic [7:0] m_st = 8'h00;
    logic m_fl = 1'b0;
    logic m1_c = 1'b0, m2_c = 1'b0, m1_i = 1'b0, m2_i = 1'b0;
    logic m_prev = 1'b0, m_iprev = 1'b0;

    always @(posedge clk) begin
        logic c_now, edge_hit, bad;
        exp_t e;
        c_now    = m2_c | m2_i;
        edge_hit = c_now && !m_prev;
        bad      = m2_i && !m_iprev && !m2_c;
        if (rst) begin
            m_st = 8'h00;
            m_fl = 1'b0;
        end else begin
            if (!load_n)        m_st = par_in;
            else if (edge_hit)  m_st = {m_st[6:0], ser_in};
            if (bad)            m_fl = 1'b1;
        end
        m_prev  = c_now;
        m_iprev = m2_i;
        m2_c = m1_c; m1_c = sclk;
        m2_i = m1_i; m1_i = sinh;
        e.q  = m_st[7];
        e.fl = m_fl;
        exp_q.push_back(e);
    end

    // Monitor: compare each cycle's expected item away from the edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0 && !done) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (q_out !== e.q) begin
                fails++;
                $display("FAIL %s: q_out=%b expected %b", tag, q_out, e.q);
            end
            checks++;
            if (q_out_n !== ~e.q) begin
                fails++;
                $display("FAIL R5: q_out_n=%b expected %b", q_out_n, ~e.q);
            end
            checks++;
            if (illegal_seen !== e.fl) begin
                fails++;
                $display("FAIL R6: illegal_seen=%b expected %b", illegal_seen, e.fl);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sclk(input int n, input logic [7:0] bits);
        for (int k = 0; k < n; k++) begin
            ser_in = bits[k];
            sclk = 1'b1; wait_cyc(4);
            sclk = 1'b0; wait_cyc(4);
        end
    endtask

    task automatic check_q(input string req, input logic expv);
        checks++;
        if (q_out !== expv) begin
            fails++;
            $display("FAIL %s: q_out=%b expected %b", req, q_out, expv);
        end
    endtask

    initial begin
        // R7: reset with combined clock high, release gives no shift
        tag = "R7";
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(6);
        check_q("R7", 1'b0);

        // R2: load while clocking and serial toggle
        tag = "R2";
        sclk = 1'b0; wait_cyc(4);
        par_in = 8'hA5; load_n = 1'b0;
        sclk = 1'b1; ser_in = 1'b0; wait_cyc(3);
        sclk = 1'b0; wait_cyc(3);
        check_q("R2", 1'b1);
        par_in = 8'h3C; wait_cyc(2);
        check_q("R2", 1'b0);

        // R8: clock edge during load is discarded
        tag = "R8";
        par_in = 8'h81;
        sclk = 1'b1; wait_cyc(6);
        load_n = 1'b1; wait_cyc(6);
        check_q("R8", 1'b1);

        // R3: par_in ignored when load high
        tag = "R3";
        par_in = 8'h00; wait_cyc(6);
        check_q("R3", 1'b1);
        sclk = 1'b0; wait_cyc(5);

        // R1 / R4: shifting with inhibit low
        tag = "R1";
        pulse_sclk(8, 8'b1100_1010);
        tag = "R4";
        pulse_sclk(3, 8'b0000_0101);

        // R4: inhibit high blocks the shift clock
        sinh = 1'b1; wait_cyc(4);
        tag = "R4";
        pulse_sclk(4, 8'hFF);
        sinh = 1'b0; wait_cyc(4);

        // R4: inhibit as the clock while sclk high (legal rise, no edge)
        sclk = 1'b1; wait_cyc(4);
        for (int k = 0; k < 3; k++) begin
            sinh = 1'b1; wait_cyc(4);
            sinh = 1'b0; wait_cyc(4);
        end
        sclk = 1'b0; wait_cyc(5);

        // R6: inhibit rising while sclk low: shift plus sticky flag
        tag = "R6";
        ser_in = 1'b1;
        sinh = 1'b1; wait_cyc(5);
        sinh = 1'b0; wait_cyc(4);
        checks++;
        if (illegal_seen !== 1'b1) begin
            fails++;
            $display("FAIL R6: illegal_seen=%b expected 1", illegal_seen);
        end
        pulse_sclk(4, 8'b0000_1011);
        wait_cyc(3);

        // R7: reset clears flag and stages
        tag = "R7";
        rst = 1'b1; wait_cyc(3);
        rst = 1'b0; wait_cyc(3);
        checks++;
        if (illegal_seen !== 1'b0 || q_out !== 1'b0) begin
            fails++;
            $display("FAIL R7: flag=%b q=%b expected 0 0", illegal_seen, q_out);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule